// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds eight one-bit lock flags that two independent ports (left and right) share. Each port has its own semaphore strobe, which is kept separate from the memory chip enable and the two byte enables. A port reads a flag and gets its value copied onto every line of its 18-bit data bus. A port writes a flag through bit 0 of its data input, and the write is taken when its read/write line goes high. The three low address bits pick the flag.

A port requests a flag by writing 0 and gives it back by writing 1. The bank makes the flags mutually exclusive. The holder reads 0 and the other port reads 1 until the holder releases. A request that cannot be granted straight away stays pending and is granted once the flag comes free. If the semaphore strobe is low while the memory chip enable is active and a byte enable is active, that access is reported as illegal and has no effect.

The read/write line is sampled in the block's clock domain. A write happens on the first clock in which read/write is seen high after it was seen low.

Top module: `sema_bank`

## Requirements
- R1: After reset all eight flags are free. A free flag reads as all ones on both ports.
- R2: A legal read drives the drive-enable output high and puts the selected flag's value on all 18 data bits. The read conditions are: strobe low, read/write high, output enable low. In every other cycle the drive-enable is low and the data output is zero.
- R3: Address bits 2:0 select one of eight independent flags. An access to one flag leaves the other seven unchanged.
- R4: A write is taken only in the cycle where read/write is sampled high after being sampled low, with the strobe low. Only data bit 0 is used: 0 is a request and 1 is a release. Bits 17:1 have no effect. If read/write stays high while the strobe is low, nothing is written.
- R5: A request for a free flag is granted on the clock edge where the write is taken. From then on the holder reads 0 and the other port reads 1.
- R6: A request for a flag that the other port holds is not granted but is kept pending. When the holder releases, the pending port is granted on the next clock edge. The pending port reads 1 for one cycle and then reads 0.
- R7: A release written by a port that does not hold the flag has no effect on the holder, and it cancels that port's own pending request.
- R8: If both ports request the same free flag on the same edge, the left port is granted and the right port becomes pending.
- R9: If the strobe is low while the chip enable is active and at least one byte enable is active, the port's illegal output goes high in that cycle. Such a write changes no flag, and such a read does not drive the bus.
- R10: With the chip enable active and both byte enables inactive, a semaphore access is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sem_n | input | 1 | Left semaphore strobe, active low |
| l_ce_n | input | 1 | Left memory chip enable, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte enable, active low |
| l_lb_n | input | 1 | Left lower byte enable, active low |
| l_addr | input | 3 | Left flag select |
| l_din | input | 18 | Left write data; only bit 0 is used |
| l_dout | output | 18 | Left read data |
| l_doe | output | 1 | Left bus drive enable |
| l_bad | output | 1 | Left illegal access |
| r_sem_n | input | 1 | Right semaphore strobe, active low |
| r_ce_n | input | 1 | Right memory chip enable, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte enable, active low |
| r_lb_n | input | 1 | Right lower byte enable, active low |
| r_addr | input | 3 | Right flag select |
| r_din | input | 18 | Right write data; only bit 0 is used |
| r_dout | output | 18 | Right read data |
| r_doe | output | 1 | Right bus drive enable |
| r_bad | output | 1 | Right illegal access |

## Verification
The bench first claims each flag from one port and reads back all eight flags from both ports, and then repeats this from the other port. This shows that flag select is correct and that the holder and non-holder views are correct. Directed sequences cover the following cases:
- a request against a held flag and then a release, which shows the one-cycle pending handover;
- simultaneous requests, which show the left-port tie-break;
- a release from the wrong port;
- a request with all of bits 17:1 set, and a strobe held with no read/write edge, which together show that only bit 0 and the rising edge count;
- chip-enable and byte-enable combinations, which separate an illegal access from a legal one.

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int DW = 18,
  parameter int NF = 8,
  localparam int AW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sem_n,
  input  logic          l_ce_n,
  input  logic          l_rw,
  input  logic          l_oe_n,
  input  logic          l_ub_n,
  input  logic          l_lb_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_din,
  output logic [DW-1:0] l_dout,
  output logic          l_doe,
  output logic          l_bad,
  input  logic          r_sem_n,
  input  logic          r_ce_n,
  input  logic          r_rw,
  input  logic          r_oe_n,
  input  logic          r_ub_n,
  input  logic          r_lb_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_din,
  output logic [DW-1:0] r_dout,
  output logic          r_doe,
  output logic          r_bad
);

  logic          l_rw_q, r_rw_q;
  logic [NF-1:0] hl, hr, pl, pr;
  logic [NF-1:0] l_sel, r_sel, l_req, r_req, l_rel, r_rel;
  logic [NF-1:0] free, gl, gr;
  logic          l_ok, r_ok, l_wr, r_wr;

  assign l_bad = !l_sem_n && !l_ce_n && (!l_ub_n || !l_lb_n);
  assign r_bad = !r_sem_n && !r_ce_n && (!r_ub_n || !r_lb_n);
  assign l_ok  = !l_sem_n && !l_bad;
  assign r_ok  = !r_sem_n && !r_bad;
  assign l_wr  = l_ok && l_rw && !l_rw_q;
  assign r_wr  = r_ok && r_rw && !r_rw_q;

  assign l_doe  = l_ok && l_rw && !l_oe_n;
  assign r_doe  = r_ok && r_rw && !r_oe_n;
  assign l_dout = l_doe ? {DW{~hl[l_addr]}} : '0;
  assign r_dout = r_doe ? {DW{~hr[r_addr]}} : '0;

  always_comb begin
    l_sel = '0;
    r_sel = '0;
    l_sel[l_addr] = l_wr;
    r_sel[r_addr] = r_wr;
  end

  assign l_req = l_sel & {NF{~l_din[0]}};
  assign l_rel = l_sel & {NF{ l_din[0]}};
  assign r_req = r_sel & {NF{~r_din[0]}};
  assign r_rel = r_sel & {NF{ r_din[0]}};

  assign free = ~hl & ~hr;
  assign gr   = free & (pr | (r_req & ~l_req & ~pl));
  assign gl   = free & ~gr & (pl | l_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rw_q <= 1'b1;
      r_rw_q <= 1'b1;
      hl <= '0;
      hr <= '0;
      pl <= '0;
      pr <= '0;
    end else begin
      l_rw_q <= l_rw;
      r_rw_q <= r_rw;
      hl <= (hl & ~l_rel) | gl;
      hr <= (hr & ~r_rel) | gr;
      pl <= ~l_rel & ~gl & ~hl & (pl | l_req);
      pr <= ~r_rel & ~gr & ~hr & (pr | r_req);
    end
  end

endmodule

module sema_bank_chk #(
  parameter int DW = 18,
  parameter int NF = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] l_dout,
  input logic          l_doe,
  input logic          l_bad,
  input logic [DW-1:0] r_dout,
  input logic          r_doe,
  input logic          r_bad,
  input logic [NF-1:0] hl,
  input logic [NF-1:0] hr,
  input logic [NF-1:0] pl,
  input logic [NF-1:0] pr
);

  a_r2_left_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    l_doe |-> (l_dout == {DW{l_dout[0]}}));
  a_r2_right_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    r_doe |-> (r_dout == {DW{r_dout[0]}}));
  a_r9_left_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    l_bad |-> !l_doe);
  a_r9_right_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    r_bad |-> !r_doe);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (hl & hr) == '0);
  a_r6_pend_not_holder: assert property (@(posedge clk) disable iff (!rst_n)
    ((pl & hl) == '0) && ((pr & hr) == '0));
  a_r6_grant_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (pr != '0 && (pr & ~hl) != '0) |=> ((hr & $past(pr & ~hl)) == $past(pr & ~hl)));

endmodule

bind sema_bank sema_bank_chk #(.DW(DW), .NF(NF)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .l_dout(l_dout), .l_doe(l_doe), .l_bad(l_bad),
  .r_dout(r_dout), .r_doe(r_doe), .r_bad(r_bad),
  .hl(hl), .hr(hr), .pl(pl), .pr(pr)
);

// File: tb/sema_bank_tb.sv
module sema_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic l_sem_n = 1, l_ce_n = 1, l_rw = 1, l_oe_n = 1, l_ub_n = 1, l_lb_n = 1;
  logic r_sem_n = 1, r_ce_n = 1, r_rw = 1, r_oe_n = 1, r_ub_n = 1, r_lb_n = 1;
  logic [2:0]  l_addr = '0, r_addr = '0;
  logic [17:0] l_din = '0, r_din = '0;
  logic [17:0] l_dout, r_dout;
  logic        l_doe, r_doe, l_bad, r_bad;

  sema_bank dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
    .l_ub_n(l_ub_n), .l_lb_n(l_lb_n), .l_addr(l_addr), .l_din(l_din),
    .l_dout(l_dout), .l_doe(l_doe), .l_bad(l_bad),
    .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
    .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_addr(r_addr), .r_din(r_din),
    .r_dout(r_dout), .r_doe(r_doe), .r_bad(r_bad)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  localparam logic [17:0] ONES = '1;

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // both-port write; en selects which ports take part
  task automatic wr2(input bit le, input bit re, input logic [2:0] la, input logic [2:0] ra,
                     input logic [17:0] ld, input logic [17:0] rd);
    @(negedge clk);
    if (le) begin l_sem_n = 0; l_rw = 0; l_addr = la; l_din = ld; end
    if (re) begin r_sem_n = 0; r_rw = 0; r_addr = ra; r_din = rd; end
    @(negedge clk);
    if (le) l_rw = 1;
    if (re) r_rw = 1;
    @(negedge clk);
    l_sem_n = 1; r_sem_n = 1;
  endtask

  task automatic wl(input logic [2:0] a, input logic [17:0] d);
    wr2(1, 0, a, 0, d, 0);
  endtask
  task automatic wrr(input logic [2:0] a, input logic [17:0] d);
    wr2(0, 1, 0, a, 0, d);
  endtask

  // reads both ports at the same moment, returns data with doe folded in
  task automatic rd2(input logic [2:0] la, input logic [2:0] ra,
                     output logic [17:0] lv, output logic [17:0] rv);
    @(negedge clk);
    l_sem_n = 0; l_rw = 1; l_oe_n = 0; l_addr = la;
    r_sem_n = 0; r_rw = 1; r_oe_n = 0; r_addr = ra;
    #1;
    lv = l_doe ? l_dout : 18'h0dead;
    rv = r_doe ? r_dout : 18'h0dead;
    l_sem_n = 1; l_oe_n = 1; r_sem_n = 1; r_oe_n = 1;
  endtask

  task automatic expect_flag(input string req, input logic [2:0] a,
                             input logic [17:0] el, input logic [17:0] er);
    logic [17:0] lv, rv;
    rd2(a, a, lv, rv);
    chk({req, " left"}, lv, el);
    chk({req, " right"}, rv, er);
  endtask

  initial begin
    logic [17:0] lv, rv;
    #1;
    chk("R2 idle doe", {17'b0, l_doe | r_doe}, 18'h0);
    chk("R2 idle data", l_dout | r_dout, 18'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: all free after reset
    for (int j = 0; j < 8; j++) expect_flag("R1 reset free", j[2:0], ONES, ONES);

    // R2: output enable high means no drive
    @(negedge clk);
    l_sem_n = 0; l_rw = 1; l_oe_n = 1; #1;
    chk("R2 oe off doe", {17'b0, l_doe}, 18'h0);
    chk("R2 oe off data", l_dout, 18'h0);
    l_sem_n = 1;

    // R3/R5 sweep: each port claims each flag, all flags read from both sides
    for (int i = 0; i < 8; i++) begin
      wl(i[2:0], 18'h0);
      for (int j = 0; j < 8; j++)
        expect_flag((i == j) ? "R5 left holds" : "R3 other flag",
                    j[2:0], (i == j) ? 18'h0 : ONES, ONES);
      wl(i[2:0], 18'h1);
      expect_flag("R3 released", i[2:0], ONES, ONES);
    end
    for (int i = 0; i < 8; i++) begin
      wrr(i[2:0], 18'h0);
      for (int j = 0; j < 8; j++)
        expect_flag((i == j) ? "R5 right holds" : "R3 other flag r",
                    j[2:0], ONES, (i == j) ? 18'h0 : ONES);
      wrr(i[2:0], 18'h1);
    end

    // R4: upper bits ignored; request with bits 17:1 set
    wl(3'd2, 18'h3fffe);
    expect_flag("R4 bit0 only", 3'd2, 18'h0, ONES);
    wl(3'd2, 18'h00001);
    // R4: strobe with rw held high, no edge -> no write
    @(negedge clk);
    l_rw = 1; l_addr = 3'd2; l_din = 18'h0; l_sem_n = 0; l_oe_n = 1;
    repeat (3) @(negedge clk);
    l_sem_n = 1;
    expect_flag("R4 no edge", 3'd2, ONES, ONES);

    // R6: right requests left-held flag, pending, handover after release
    wl(3'd4, 18'h0);
    wrr(3'd4, 18'h0);
    expect_flag("R6 still left", 3'd4, 18'h0, ONES);
    @(negedge clk);
    l_sem_n = 0; l_rw = 0; l_addr = 3'd4; l_din = 18'h1;
    @(negedge clk);
    l_rw = 1;
    @(negedge clk);
    l_sem_n = 1;
    r_sem_n = 0; r_rw = 1; r_oe_n = 0; r_addr = 3'd4; #1;
    chk("R6 one cycle free", r_dout, ONES);
    @(negedge clk); #1;
    chk("R6 granted next", r_dout, 18'h0);
    r_sem_n = 1; r_oe_n = 1;
    expect_flag("R6 right holds", 3'd4, ONES, 18'h0);

    // R7: wrong-port release has no effect; cancels own pending
    wl(3'd4, 18'h1);
    expect_flag("R7 holder kept", 3'd4, ONES, 18'h0);
    wl(3'd4, 18'h0);
    wl(3'd4, 18'h1);
    wrr(3'd4, 18'h1);
    repeat (2) @(negedge clk);
    expect_flag("R7 pending cancelled", 3'd4, ONES, ONES);

    // R8: simultaneous request, left wins, right pending
    wr2(1, 1, 3'd6, 3'd6, 18'h0, 18'h0);
    expect_flag("R8 left wins", 3'd6, 18'h0, ONES);
    wl(3'd6, 18'h1);
    @(negedge clk);
    expect_flag("R8 right after", 3'd6, ONES, 18'h0);
    wrr(3'd6, 18'h1);

    // R9: illegal access flagged and ignored
    @(negedge clk);
    l_ce_n = 0; l_ub_n = 0; l_sem_n = 0; l_rw = 0; l_addr = 3'd5; l_din = 18'h0;
    #1; chk("R9 bad flagged", {17'b0, l_bad}, 18'h1);
    @(negedge clk);
    l_rw = 1; l_oe_n = 0; #1;
    chk("R9 no drive", {17'b0, l_doe}, 18'h0);
    @(negedge clk);
    l_sem_n = 1; l_oe_n = 1; l_ub_n = 1; l_lb_n = 0; #1;
    chk("R9 strobe high ok", {17'b0, l_bad}, 18'h0);
    l_lb_n = 1; l_ce_n = 1;
    expect_flag("R9 write ignored", 3'd5, ONES, ONES);

    // R10: ce active, both bytes off -> legal
    @(negedge clk);
    r_ce_n = 0; r_sem_n = 0; r_rw = 0; r_addr = 3'd7; r_din = 18'h0;
    #1; chk("R10 not bad", {17'b0, r_bad}, 18'h0);
    @(negedge clk);
    r_rw = 1;
    @(negedge clk);
    r_sem_n = 1;
    rd2(3'd7, 3'd7, lv, rv);
    chk("R10 right claimed", rv, 18'h0);
    chk("R10 left sees taken", lv, ONES);
    r_ce_n = 1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule